// File: doc/BRIEF.md
# Sensor Event Interrupt Generator

This block watches the stream of values written into a bank of function slots and raises an interrupt line to the host when a slot's programmed condition becomes true. Each slot holds its own event configuration: a compare mode, a low bound (also the threshold for the single-value compares), a high bound, an operand source (the written function result or one of the raw sensor inputs), and an interrupt enable. All values are signed two's-complement numbers.

A slot is evaluated only on a cycle where an update for that slot arrives. One compare unit is shared by all slots, since at most one update arrives per cycle. Each slot runs a small arming state machine with two states. `ARM_WAIT` means the condition was last seen false. `ARM_TRIPPED` means it was last seen true. The transition *fire* (`ARM_WAIT` to `ARM_TRIPPED`) happens on an update whose condition is true, and it sets the slot's pending bit. The transition *release* (`ARM_TRIPPED` to `ARM_WAIT`) happens on an update whose condition is false. The transition *rearm* (any state to `ARM_WAIT`) happens on a configuration write to that slot. The host reads the pending vector and clears bits by writing ones. The interrupt line is the OR of the pending bits whose slot enable is set.

Top module: `sev_irq_gen`

## Requirements
- R1: After reset, all pending bits and `irq` are 0, and every slot's mode is 0 (disabled).
- R2: Mode 1 (less-than) is true when the operand is below `lo`, using a signed compare.
- R3: Mode 2 (greater-than) is true when the operand is above `lo`, using a signed compare.
- R4: Mode 3 (equal) is true when the operand equals `lo`.
- R5: Mode 4 (inside-range) is true when lo ≤ operand ≤ hi, with both ends included and a signed compare.
- R6: Mode 5 (outside-range) is true exactly when the mode 4 test is false.
- R7: Mode 0 and the unused codes 6 and 7 never set a pending bit.
- R8: A pending bit is set only when the slot's condition goes from false to true. A later true update does not set it again until a false update has re-armed the slot. At most one pending bit is newly set per cycle.
- R9: A condition is evaluated only on a cycle with `upd_valid` high for that slot. Changes on `sensor_vals` alone, and updates to other slots, leave a slot's pending bit unchanged.
- R10: A slot whose source flag is 1 compares `sensor_vals[sel*16 +: 16]` (the selected sensor) and ignores `upd_value`.
- R11: `irq` equals the OR over slots of (pending AND slot enable). A pending bit is set whatever the enable is.
- R12: Writing `clr_mask` with `clr_we` clears the pending bits at the one positions. Zero bits have no effect. A bit that fires in the same cycle as its clear stays set.
- R13: A configuration write to a slot returns it to `ARM_WAIT` and leaves its pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Slot being configured |
| cfg_mode | input | 3 | Compare mode code (0 to 5) |
| cfg_src_sens | input | 1 | 1 selects a raw sensor as the operand |
| cfg_sens_sel | input | SEL_W | Sensor index used when the source flag is 1 |
| cfg_irq_en | input | 1 | Slot interrupt enable |
| cfg_lo | input | DATA_W | Threshold, or the low range bound |
| cfg_hi | input | DATA_W | High range bound |
| upd_valid | input | 1 | A new value is written to a slot |
| upd_slot | input | SLOT_W | Slot being updated |
| upd_value | input | DATA_W | Function result being written |
| sensor_vals | input | NUM_SENS*DATA_W | Raw sensor values, sensor k at bits k*DATA_W |
| clr_we | input | 1 | Pending clear strobe |
| clr_mask | input | NUM_SLOTS | Write-one-to-clear mask |
| pending | output | NUM_SLOTS | Pending event bits |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with four slots, two sensors and 16-bit data. With four slots it can reach cross-slot isolation and a one-cycle set-versus-clear race. With two sensors it can show that the source selector really chooses the sensor. For modes 1 to 5 it sweeps the operand through every value from -8 to 8 plus the two extreme 16-bit values, against fixed bounds of -3 and 4. Every bound edge and the sign wrap are therefore checked against expected values that the bench computes arithmetically.

// File: rtl/sev_pkg.sv
package sev_pkg;

    // Compare mode codes; 6 and 7 are unused and never true.
    typedef enum logic [2:0] {
        EVM_OFF     = 3'd0,
        EVM_BELOW   = 3'd1,
        EVM_ABOVE   = 3'd2,
        EVM_MATCH   = 3'd3,
        EVM_INSIDE  = 3'd4,
        EVM_OUTSIDE = 3'd5
    } sev_mode_e;

    // Per-slot arming state.
    typedef enum logic {
        ARM_WAIT    = 1'b0,
        ARM_TRIPPED = 1'b1
    } sev_arm_e;

endpackage

// File: rtl/sev_cfg_bank.sv
module sev_cfg_bank
    import sev_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 16,
    parameter int SEL_W     = 2,
    parameter int SLOT_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [SLOT_W-1:0]        cfg_slot,
    input  logic [2:0]               cfg_mode,
    input  logic                     cfg_src_sens,
    input  logic [SEL_W-1:0]         cfg_sens_sel,
    input  logic                     cfg_irq_en,
    input  logic [DATA_W-1:0]        cfg_lo,
    input  logic [DATA_W-1:0]        cfg_hi,
    output sev_mode_e                mode_o   [NUM_SLOTS],
    output logic                     src_o    [NUM_SLOTS],
    output logic [SEL_W-1:0]         sel_o    [NUM_SLOTS],
    output logic [DATA_W-1:0]        lo_o     [NUM_SLOTS],
    output logic [DATA_W-1:0]        hi_o     [NUM_SLOTS],
    output logic [NUM_SLOTS-1:0]     ien_o,
    output logic [NUM_SLOTS-1:0]     rearm_o
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic wr_this;
        assign wr_this    = cfg_we && (cfg_slot == SLOT_W'(g));
        assign rearm_o[g] = wr_this;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_o[g]  <= EVM_OFF;
                src_o[g]   <= 1'b0;
                sel_o[g]   <= '0;
                lo_o[g]    <= '0;
                hi_o[g]    <= '0;
                ien_o[g]   <= 1'b0;
            end else if (wr_this) begin
                mode_o[g]  <= sev_mode_e'(cfg_mode);
                src_o[g]   <= cfg_src_sens;
                sel_o[g]   <= cfg_sens_sel;
                lo_o[g]    <= cfg_lo;
                hi_o[g]    <= cfg_hi;
                ien_o[g]   <= cfg_irq_en;
            end
        end
    end

endmodule

// File: rtl/sev_operand_sel.sv
module sev_operand_sel
    import sev_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_SENS  = 4,
    parameter int DATA_W    = 16,
    parameter int SEL_W     = 2,
    parameter int SLOT_W    = 3
) (
    input  logic                         upd_valid,
    input  logic [SLOT_W-1:0]            upd_slot,
    input  logic [DATA_W-1:0]            upd_value,
    input  logic [NUM_SENS*DATA_W-1:0]   sensor_vals,
    input  sev_mode_e                    mode_i [NUM_SLOTS],
    input  logic                         src_i  [NUM_SLOTS],
    input  logic [SEL_W-1:0]             sel_i  [NUM_SLOTS],
    input  logic [DATA_W-1:0]            lo_i   [NUM_SLOTS],
    input  logic [DATA_W-1:0]            hi_i   [NUM_SLOTS],
    output sev_mode_e                    mode_o,
    output logic [DATA_W-1:0]            lo_o,
    output logic [DATA_W-1:0]            hi_o,
    output logic [DATA_W-1:0]            operand_o,
    output logic [NUM_SLOTS-1:0]         hit_o
);

    logic             src_s;
    logic [SEL_W-1:0] sel_s;
    logic [DATA_W-1:0] sens_s;

    // Pick the configuration of the slot being updated.
    always_comb begin
        mode_o = EVM_OFF;
        lo_o   = '0;
        hi_o   = '0;
        src_s  = 1'b0;
        sel_s  = '0;
        hit_o  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (upd_slot == SLOT_W'(i)) begin
                mode_o   = mode_i[i];
                lo_o     = lo_i[i];
                hi_o     = hi_i[i];
                src_s    = src_i[i];
                sel_s    = sel_i[i];
                hit_o[i] = upd_valid;
            end
        end
    end

    // Raw sensor mux; an index beyond the sensor count reads zero.
    always_comb begin
        sens_s = '0;
        for (int k = 0; k < NUM_SENS; k++) begin
            if (sel_s == SEL_W'(k)) begin
                sens_s = sensor_vals[k*DATA_W +: DATA_W];
            end
        end
    end

    assign operand_o = src_s ? sens_s : upd_value;

endmodule

// File: rtl/sev_compare.sv
module sev_compare
    import sev_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sev_mode_e          mode,
    input  logic [DATA_W-1:0]  operand,
    input  logic [DATA_W-1:0]  lo,
    input  logic [DATA_W-1:0]  hi,
    output logic               cond
);

    logic signed [DATA_W-1:0] x_s;
    logic signed [DATA_W-1:0] lo_s;
    logic signed [DATA_W-1:0] hi_s;
    logic                     in_rng;

    assign x_s    = operand;
    assign lo_s   = lo;
    assign hi_s   = hi;
    assign in_rng = (x_s >= lo_s) && (x_s <= hi_s);

    always_comb begin
        unique case (mode)
            EVM_BELOW:   cond = (x_s < lo_s);
            EVM_ABOVE:   cond = (x_s > lo_s);
            EVM_MATCH:   cond = (x_s == lo_s);
            EVM_INSIDE:  cond = in_rng;
            EVM_OUTSIDE: cond = !in_rng;
            default:     cond = 1'b0;
        endcase
    end

endmodule

// File: rtl/sev_slot_arm.sv
module sev_slot_arm
    import sev_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rearm,
    input  logic     hit,
    input  logic     cond,
    input  logic     clr,
    output sev_arm_e state,
    output logic     pend
);

    sev_arm_e st_q;
    sev_arm_e st_d;
    logic     fire;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ARM_WAIT;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARM_WAIT:    if (hit && cond)  st_d = ARM_TRIPPED;
            ARM_TRIPPED: if (hit && !cond) st_d = ARM_WAIT;
        endcase
        if (rearm) st_d = ARM_WAIT;
    end

    assign fire = (st_q == ARM_WAIT) && hit && cond;

    // Output: pending bit, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (fire) pend <= 1'b1;
        else if (clr)  pend <= 1'b0;
    end

    assign state = st_q;

endmodule

// File: rtl/sev_irq_gen.sv
module sev_irq_gen
    import sev_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_SENS  = 4,
    parameter int DATA_W    = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int SEL_W    = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [SLOT_W-1:0]            cfg_slot,
    input  logic [2:0]                   cfg_mode,
    input  logic                         cfg_src_sens,
    input  logic [SEL_W-1:0]             cfg_sens_sel,
    input  logic                         cfg_irq_en,
    input  logic [DATA_W-1:0]            cfg_lo,
    input  logic [DATA_W-1:0]            cfg_hi,
    input  logic                         upd_valid,
    input  logic [SLOT_W-1:0]            upd_slot,
    input  logic [DATA_W-1:0]            upd_value,
    input  logic [NUM_SENS*DATA_W-1:0]   sensor_vals,
    input  logic                         clr_we,
    input  logic [NUM_SLOTS-1:0]         clr_mask,
    output logic [NUM_SLOTS-1:0]         pending,
    output logic                         irq
);

    sev_mode_e           mode_a [NUM_SLOTS];
    logic                src_a  [NUM_SLOTS];
    logic [SEL_W-1:0]    sel_a  [NUM_SLOTS];
    logic [DATA_W-1:0]   lo_a   [NUM_SLOTS];
    logic [DATA_W-1:0]   hi_a   [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] ien;
    logic [NUM_SLOTS-1:0] rearm;

    sev_mode_e           cur_mode;
    logic [DATA_W-1:0]   cur_lo;
    logic [DATA_W-1:0]   cur_hi;
    logic [DATA_W-1:0]   cur_x;
    logic [NUM_SLOTS-1:0] hit;
    logic                cond;
    sev_arm_e            arm_st [NUM_SLOTS];

    sev_cfg_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .SLOT_W    (SLOT_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_slot     (cfg_slot),
        .cfg_mode     (cfg_mode),
        .cfg_src_sens (cfg_src_sens),
        .cfg_sens_sel (cfg_sens_sel),
        .cfg_irq_en   (cfg_irq_en),
        .cfg_lo       (cfg_lo),
        .cfg_hi       (cfg_hi),
        .mode_o       (mode_a),
        .src_o        (src_a),
        .sel_o        (sel_a),
        .lo_o         (lo_a),
        .hi_o         (hi_a),
        .ien_o        (ien),
        .rearm_o      (rearm)
    );

    sev_operand_sel #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_SENS  (NUM_SENS),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .SLOT_W    (SLOT_W)
    ) u_sel (
        .upd_valid   (upd_valid),
        .upd_slot    (upd_slot),
        .upd_value   (upd_value),
        .sensor_vals (sensor_vals),
        .mode_i      (mode_a),
        .src_i       (src_a),
        .sel_i       (sel_a),
        .lo_i        (lo_a),
        .hi_i        (hi_a),
        .mode_o      (cur_mode),
        .lo_o        (cur_lo),
        .hi_o        (cur_hi),
        .operand_o   (cur_x),
        .hit_o       (hit)
    );

    sev_compare #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .mode    (cur_mode),
        .operand (cur_x),
        .lo      (cur_lo),
        .hi      (cur_hi),
        .cond    (cond)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_arm
        sev_slot_arm u_arm (
            .clk   (clk),
            .rst_n (rst_n),
            .rearm (rearm[g]),
            .hit   (hit[g]),
            .cond  (cond),
            .clr   (clr_we && clr_mask[g]),
            .state (arm_st[g]),
            .pend  (pending[g])
        );
    end

    assign irq = |(pending & ien);

endmodule

// File: rtl/sev_irq_gen_chk.sv
module sev_irq_gen_chk #(
    parameter int NUM_SLOTS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 upd_valid,
    input logic                 clr_we,
    input logic [NUM_SLOTS-1:0] clr_mask,
    input logic [NUM_SLOTS-1:0] pending,
    input logic                 irq
);

    // R11
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> !irq);

    // R9
    no_set_without_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ((pending & ~$past(pending)) == '0));

    // R8
    one_new_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pending & ~$past(pending)));

    // R12
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !upd_valid) |=> ((pending & $past(clr_mask)) == '0));

    // R12
    zero_mask_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((pending & $past(pending)) == $past(pending)));

endmodule

bind sev_irq_gen sev_irq_gen_chk #(.NUM_SLOTS(NUM_SLOTS)) u_sev_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .pending   (pending),
    .irq       (irq)
);

// File: tb/test_sev_irq_gen.sv
`timescale 1ns/1ps
module test_sev_irq_gen;

    localparam int NS = 4;
    localparam int NE = 2;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_slot = '0;
    logic [2:0]    cfg_mode = '0;
    logic          cfg_src_sens = 1'b0;
    logic [0:0]    cfg_sens_sel = '0;
    logic          cfg_irq_en = 1'b0;
    logic [DW-1:0] cfg_lo = '0;
    logic [DW-1:0] cfg_hi = '0;
    logic          upd_valid = 1'b0;
    logic [1:0]    upd_slot = '0;
    logic [DW-1:0] upd_value = '0;
    logic [NE*DW-1:0] sensor_vals = '0;
    logic          clr_we = 1'b0;
    logic [NS-1:0] clr_mask = '0;
    logic [NS-1:0] pending;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sev_irq_gen #(.NUM_SLOTS(NS), .NUM_SENS(NE), .DATA_W(DW)) i_sev_irq_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
        .cfg_src_sens(cfg_src_sens), .cfg_sens_sel(cfg_sens_sel),
        .cfg_irq_en(cfg_irq_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .upd_valid(upd_valid), .upd_slot(upd_slot), .upd_value(upd_value),
        .sensor_vals(sensor_vals), .clr_we(clr_we), .clr_mask(clr_mask),
        .pending(pending), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // All drives happen at the falling edge; results are read at the next falling edge.
    task automatic cfg(input int slot, input int mode, input bit src, input int sel,
                       input bit en, input int lo, input int hi);
        cfg_we = 1'b1; cfg_slot = 2'(slot); cfg_mode = 3'(mode);
        cfg_src_sens = src; cfg_sens_sel = 1'(sel); cfg_irq_en = en;
        cfg_lo = DW'(lo); cfg_hi = DW'(hi);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic upd_clr(input bit u, input int slot, input int val,
                           input bit c, input int mask);
        upd_valid = u; upd_slot = 2'(slot); upd_value = DW'(val);
        clr_we = c; clr_mask = NS'(mask);
        @(negedge clk);
        upd_valid = 1'b0; clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic upd(input int slot, input int val);
        upd_clr(1'b1, slot, val, 1'b0, 0);
    endtask

    task automatic clr(input int mask);
        upd_clr(1'b0, 0, 0, 1'b1, mask);
    endtask

    function automatic int sweep_x(input int i);
        if (i == 0)  return -32768;
        if (i == 18) return 32767;
        return i - 9;
    endfunction

    function automatic int expect_cond(input int mode, input int x, input int lo, input int hi);
        case (mode)
            1: return (x < lo) ? 1 : 0;
            2: return (x > lo) ? 1 : 0;
            3: return (x == lo) ? 1 : 0;
            4: return (x >= lo && x <= hi) ? 1 : 0;
            5: return (x < lo || x > hi) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, and a slot in its reset mode never fires
        chk("R1 pending", int'(pending), 0);
        chk("R1 irq", int'(irq), 0);
        upd(0, 0);
        upd(1, -5);
        chk("R1 reset mode off", int'(pending), 0);

        // R2..R6: sweep each mode on slot 1 against lo=-3, hi=4
        for (int m = 1; m <= 5; m++) begin
            for (int i = 0; i < 19; i++) begin
                int x;
                int e;
                string tag;
                x = sweep_x(i);
                e = expect_cond(m, x, -3, 4);
                tag = (m == 1) ? "R2" : (m == 2) ? "R3" : (m == 3) ? "R4" :
                      (m == 4) ? "R5" : "R6";
                cfg(1, m, 1'b0, 0, 1'b1, -3, 4);
                clr(4'hF);
                upd(1, x);
                chk({tag, " pending"}, int'(pending[1]), e);
                chk({tag, " irq"}, int'(irq), e);
            end
        end

        // R7: disabled and unused codes never fire
        for (int m = 0; m < 8; m = (m == 0) ? 6 : m + 1) begin
            for (int i = 0; i < 19; i += 3) begin
                cfg(2, m, 1'b0, 0, 1'b1, -3, 4);
                clr(4'hF);
                upd(2, sweep_x(i));
                chk("R7 no event", int'(pending), 0);
            end
        end

        // R8 / R13: edge-triggered setting and re-arming
        cfg(0, 2, 1'b0, 0, 1'b1, 0, 0);
        clr(4'hF);
        upd(0, 5);
        chk("R8 first true", int'(pending[0]), 1);
        clr(4'h1);
        upd(0, 6);
        chk("R8 still true no reset", int'(pending[0]), 0);
        upd(0, -1);
        chk("R8 false keeps clear", int'(pending[0]), 0);
        upd(0, 3);
        chk("R8 re-armed fires", int'(pending[0]), 1);
        clr(4'h1);
        cfg(0, 2, 1'b0, 0, 1'b1, 0, 0);
        chk("R13 cfg keeps pending clear", int'(pending[0]), 0);
        upd(0, 7);
        chk("R13 cfg re-arms", int'(pending[0]), 1);
        cfg(0, 2, 1'b0, 0, 1'b1, 0, 0);
        chk("R13 cfg leaves pending set", int'(pending[0]), 1);

        // R10: sensor source on slot 2, sensor 1
        clr(4'hF);
        cfg(2, 3, 1'b1, 1, 1'b1, 77, 0);
        sensor_vals = {16'sd77, 16'sd5};
        upd(2, 0);
        chk("R10 sensor match", int'(pending[2]), 1);
        clr(4'hF);
        cfg(2, 3, 1'b1, 1, 1'b1, 77, 0);
        sensor_vals = {16'sd5, 16'sd77};
        upd(2, 77);
        chk("R10 written value ignored", int'(pending[2]), 0);

        // R9: sensor change alone, and updates to other slots, have no effect
        sensor_vals = {16'sd77, 16'sd77};
        @(negedge clk);
        @(negedge clk);
        chk("R9 sensor alone", int'(pending[2]), 0);
        cfg(3, 2, 1'b0, 0, 1'b1, 0, 0);
        upd(3, 9);
        chk("R9 other slot only", int'(pending), 8);

        // R11: enable gates irq only
        clr(4'hF);
        cfg(0, 1, 1'b0, 0, 1'b0, 0, 0);
        upd(0, -4);
        chk("R11 pending without enable", int'(pending), 1);
        chk("R11 irq masked", int'(irq), 0);
        cfg(0, 1, 1'b0, 0, 1'b1, 0, 0);
        chk("R11 irq after enable", int'(irq), 1);

        // R12: zero mask, partial clear, set wins over clear
        cfg(3, 2, 1'b0, 0, 1'b1, 0, 0);
        upd(3, 1);
        clr(0);
        chk("R12 zero mask keeps", int'(pending), 9);
        clr(4'h8);
        chk("R12 partial clear", int'(pending), 1);
        cfg(0, 1, 1'b0, 0, 1'b1, 0, 0);
        upd_clr(1'b1, 0, -2, 1'b1, 1);
        chk("R12 set beats clear", int'(pending[0]), 1);
        clr(4'h1);
        chk("R12 final clear", int'(pending), 0);
        chk("R12 irq drops", int'(irq), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule